// File: doc/BRIEF.md
# CCD Clock and Sampling Timing Generator

This block drives a linear CCD sensor from a single master clock. It produces two complementary shift clocks, a per-pixel reset pulse, and a once-per-line transfer-gate pulse. It also produces two one-cycle sampling strobes: one for the black reference and one for the video signal. Each pixel period is 16 master clocks long. A 4-bit phase counter runs through that period, and the reset pulse and both strobes fire at programmed phases of it.

Each line has a fixed sequence. It starts with a guard interval, then the transfer pulse, then a second guard interval of the same length. Pixels are clocked out after that. They come in three groups: dummy pixels, optical-black pixels, and a fixed number of active pixels. A region code tells the downstream data path which group the current pixel belongs to.

All timing and polarity settings come in on configuration inputs. These are buffered in shadow registers and only take effect at a line boundary, so a setting change can never cut a pulse short.

Top module: `ccd_timing_gen`

## Requirements
- R1: In the pixel section, with no inversion and both clock enables set, `phi1` is 1 for phases 0..7 of each 16-cycle pixel period and 0 for phases 8..15, and `phi2` is its complement.
- R2: `rs` is active from phase `cfg_rs_pos` for `cfg_rs_width`+1 cycles of each pixel period (a width field of 0 gives one cycle). The pulse does not wrap past phase 15.
- R3: `sr` and `ss` are each high for exactly one cycle per pixel, at phases `cfg_sr_pos` and `cfg_ss_pos` respectively. They are never high outside the pixel section.
- R4: Each line runs in this order:
  - a guard interval of 20+`cfg_guard` cycles;
  - the transfer pulse, active for 20+`cfg_tr_width` cycles;
  - a second guard interval of 20+`cfg_guard` cycles;
  - the pixels, each 16 cycles long.

  Outside the pixel section the shift clocks are frozen with the raw `phi1` level at 1 and `phi2` at 0.
- R5: Enable bits are `cfg_en[0]` for `phi1`, `cfg_en[1]` for `phi2`, `cfg_en[2]` for `rs` and `cfg_en[3]` for `tr`. A disabled output stays at its inactive level. That level is 0, or 1 when the output is inverted.
- R6: `cfg_rs_inv` and `cfg_tr_inv` independently invert `rs` and `tr`. A value of 0 gives an active-high pulse.
- R7: When `cfg_clk_inv` is 1, both gated shift clocks are inverted, and then `phi1` is driven from the inverted `phi2` and `phi2` from the inverted `phi1`.
- R8: The pixel section has `cfg_dummy` dummy pixels, then `cfg_ob` optical-black pixels, then ACTIVE_PIX active pixels (default 8). `region` shows 1 for dummy, 2 for optical black, 3 for active, and 0 outside the pixel section.
- R9: The configuration inputs are captured during reset and in the last cycle of every line. Changes at any other time have no effect until the next line.
- R10: `line_start` is high only in the first cycle of each line. `sig_pol` carries the captured `cfg_sig_inv` bit.
- R11: After synchronous reset the block is in the first cycle of a line's leading guard interval, with `region` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_rs_width | input | 4 | Reset pulse width minus one |
| cfg_rs_pos | input | 4 | Phase at which the reset pulse starts |
| cfg_sr_pos | input | 4 | Phase of the black-reference strobe |
| cfg_ss_pos | input | 4 | Phase of the signal strobe |
| cfg_tr_width | input | 4 | Transfer pulse width beyond 20 cycles |
| cfg_guard | input | 4 | Guard interval beyond 20 cycles |
| cfg_dummy | input | 4 | Dummy pixels per line |
| cfg_ob | input | 4 | Optical-black pixels per line |
| cfg_en | input | 4 | Output enables: phi1, phi2, rs, tr |
| cfg_rs_inv | input | 1 | Reset pulse inversion |
| cfg_tr_inv | input | 1 | Transfer pulse inversion |
| cfg_clk_inv | input | 1 | Shift clock inversion with pin swap |
| cfg_sig_inv | input | 1 | Video polarity flag for the data path |
| phi1 | output | 1 | Shift clock 1 |
| phi2 | output | 1 | Shift clock 2 |
| rs | output | 1 | Reset pulse |
| tr | output | 1 | Transfer gate pulse |
| sr | output | 1 | Black-reference sample strobe |
| ss | output | 1 | Signal sample strobe |
| region | output | 2 | Pixel region code |
| line_start | output | 1 | First cycle of a line |
| sig_pol | output | 1 | Captured video polarity |

## Verification
A wrong phase count shows up within one 16-cycle pixel period, because the `phi1` edge or a strobe lands at the wrong phase. A wrong interval counter moves the transfer pulse edges and the first pixel, so the fault is visible before the line's first pixel. An off-by-one in the pixel counter shifts the region boundaries and the line length, and that becomes visible at the next `line_start`. A shadow register that loads at the wrong time shows up as a pulse width or polarity change in the middle of a line.

// File: rtl/ccd_tg_pkg.sv
`timescale 1ns/1ps
package ccd_tg_pkg;
    localparam int FLD_W = 4;
    localparam int PH_W  = 4;

    localparam int EN_PHI1 = 0;
    localparam int EN_PHI2 = 1;
    localparam int EN_RS   = 2;
    localparam int EN_TR   = 3;

    typedef struct packed {
        logic [FLD_W-1:0] rs_width;
        logic [FLD_W-1:0] rs_pos;
        logic [FLD_W-1:0] sr_pos;
        logic [FLD_W-1:0] ss_pos;
        logic [FLD_W-1:0] tr_width;
        logic [FLD_W-1:0] guard;
        logic [FLD_W-1:0] dummy;
        logic [FLD_W-1:0] ob;
        logic [3:0]       en;
        logic             rs_inv;
        logic             tr_inv;
        logic             clk_inv;
        logic             sig_inv;
    } tg_cfg_t;

    typedef enum logic [1:0] {
        ST_LEAD  = 2'd0,
        ST_XFER  = 2'd1,
        ST_TRAIL = 2'd2,
        ST_PIX   = 2'd3
    } seq_st_e;

    typedef enum logic [1:0] {
        RG_NONE   = 2'd0,
        RG_DUMMY  = 2'd1,
        RG_OB     = 2'd2,
        RG_ACTIVE = 2'd3
    } region_e;

    // true when phase lies in [start, start+len_m1] without wrapping
    function automatic logic in_window(input logic [PH_W-1:0] ph,
                                       input logic [PH_W-1:0] start,
                                       input logic [FLD_W-1:0] len_m1);
        logic [PH_W:0] off;
        off = {1'b0, ph} - {1'b0, start};
        return (ph >= start) && (off <= {1'b0, len_m1});
    endfunction
endpackage

// File: rtl/ccd_line_seq.sv
`timescale 1ns/1ps
module ccd_line_seq
    import ccd_tg_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int PIX_W      = 8,
    parameter int ACTIVE_PIX = 8,
    parameter int TR_MIN     = 20,
    parameter int GUARD_MIN  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  tg_cfg_t           cfg_in,
    output tg_cfg_t           cfg_act,
    output seq_st_e           st,
    output logic [PH_W-1:0]   phase,
    output logic [PIX_W-1:0]  pix,
    output logic              line_start
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] guard_last;
    logic [CNT_W-1:0] xfer_last;
    logic [PIX_W-1:0] pix_last;
    logic             line_end;

    always_comb begin
        guard_last = CNT_W'(GUARD_MIN) + CNT_W'(cfg_act.guard) - CNT_W'(1);
        xfer_last  = CNT_W'(TR_MIN) + CNT_W'(cfg_act.tr_width) - CNT_W'(1);
        pix_last   = PIX_W'(cfg_act.dummy) + PIX_W'(cfg_act.ob) + PIX_W'(ACTIVE_PIX - 1);
        line_end   = (st == ST_PIX) && (&phase) && (pix == pix_last);
        line_start = (st == ST_LEAD) && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_LEAD;
            cnt     <= '0;
            phase   <= '0;
            pix     <= '0;
            cfg_act <= cfg_in;
        end else begin
            unique case (st)
                ST_LEAD: begin
                    if (cnt == guard_last) begin
                        st  <= ST_XFER;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_XFER: begin
                    if (cnt == xfer_last) begin
                        st  <= ST_TRAIL;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_TRAIL: begin
                    if (cnt == guard_last) begin
                        st    <= ST_PIX;
                        cnt   <= '0;
                        phase <= '0;
                        pix   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_PIX: begin
                    phase <= phase + PH_W'(1);
                    if (&phase) begin
                        if (line_end) begin
                            st      <= ST_LEAD;
                            pix     <= '0;
                            cfg_act <= cfg_in;
                        end else begin
                            pix <= pix + PIX_W'(1);
                        end
                    end
                end
                default: st <= ST_LEAD;
            endcase
        end
    end

    // R9: shadow configuration only moves at a line boundary
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(cfg_act));

    // R4: the transfer pulse is entered only from the leading guard
    a_r4_xfer_order: assert property (@(posedge clk) disable iff (rst)
        (st == ST_XFER) |-> ($past(st) == ST_LEAD || $past(st) == ST_XFER));

    // R10: line start lasts a single cycle
    a_r10_start_single: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start);
endmodule

// File: rtl/ccd_pix_decode.sv
`timescale 1ns/1ps
module ccd_pix_decode
    import ccd_tg_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_st_e           st,
    input  logic [PH_W-1:0]   phase,
    input  logic [PIX_W-1:0]  pix,
    input  logic [FLD_W-1:0]  rs_pos,
    input  logic [FLD_W-1:0]  rs_width,
    input  logic [FLD_W-1:0]  sr_pos,
    input  logic [FLD_W-1:0]  ss_pos,
    input  logic [FLD_W-1:0]  dummy,
    input  logic [FLD_W-1:0]  ob,
    output logic              phi_lvl,
    output logic              rs_act,
    output logic              tr_act,
    output logic              sr,
    output logic              ss,
    output region_e           region
);
    localparam int PW1 = PIX_W + 1;

    logic          in_pix;
    logic [PW1-1:0] dmy_end;
    logic [PW1-1:0] ob_end;

    always_comb begin
        in_pix  = (st == ST_PIX);
        phi_lvl = in_pix ? ~phase[PH_W-1] : 1'b1;
        tr_act  = (st == ST_XFER);
        rs_act  = in_pix && in_window(phase, rs_pos, rs_width);
        sr      = in_pix && (phase == sr_pos);
        ss      = in_pix && (phase == ss_pos);
        dmy_end = PW1'(dummy);
        ob_end  = dmy_end + PW1'(ob);
        if (!in_pix)
            region = RG_NONE;
        else if (PW1'(pix) < dmy_end)
            region = RG_DUMMY;
        else if (PW1'(pix) < ob_end)
            region = RG_OB;
        else
            region = RG_ACTIVE;
    end

    // R3: each strobe is a single cycle per pixel period
    a_r3_sr_single: assert property (@(posedge clk) disable iff (rst)
        sr |=> !sr);
    a_r3_ss_single: assert property (@(posedge clk) disable iff (rst)
        ss |=> !ss);
endmodule

// File: rtl/ccd_out_drive.sv
`timescale 1ns/1ps
module ccd_out_drive
    import ccd_tg_pkg::*;
(
    input  logic       phi_lvl,
    input  logic       rs_act,
    input  logic       tr_act,
    input  logic [3:0] en,
    input  logic       rs_inv,
    input  logic       tr_inv,
    input  logic       clk_inv,
    output logic       phi1,
    output logic       phi2,
    output logic       rs,
    output logic       tr
);
    logic g1, g2;

    always_comb begin
        g1   = phi_lvl & en[EN_PHI1];
        g2   = ~phi_lvl & en[EN_PHI2];
        // inverted clocks swap pins so the sensor still sees phase order
        phi1 = clk_inv ? ~g2 : g1;
        phi2 = clk_inv ? ~g1 : g2;
        rs   = (rs_act & en[EN_RS]) ^ rs_inv;
        tr   = (tr_act & en[EN_TR]) ^ tr_inv;
    end
endmodule

// File: rtl/ccd_timing_gen.sv
`timescale 1ns/1ps
module ccd_timing_gen
    import ccd_tg_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int PIX_W      = 8,
    parameter int ACTIVE_PIX = 8,
    parameter int TR_MIN     = 20,
    parameter int GUARD_MIN  = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] cfg_rs_width,
    input  logic [3:0] cfg_rs_pos,
    input  logic [3:0] cfg_sr_pos,
    input  logic [3:0] cfg_ss_pos,
    input  logic [3:0] cfg_tr_width,
    input  logic [3:0] cfg_guard,
    input  logic [3:0] cfg_dummy,
    input  logic [3:0] cfg_ob,
    input  logic [3:0] cfg_en,
    input  logic       cfg_rs_inv,
    input  logic       cfg_tr_inv,
    input  logic       cfg_clk_inv,
    input  logic       cfg_sig_inv,
    output logic       phi1,
    output logic       phi2,
    output logic       rs,
    output logic       tr,
    output logic       sr,
    output logic       ss,
    output logic [1:0] region,
    output logic       line_start,
    output logic       sig_pol
);
    tg_cfg_t          cfg_in, cfg_act;
    seq_st_e          st;
    logic [PH_W-1:0]  phase;
    logic [PIX_W-1:0] pix;
    logic             phi_lvl, rs_act, tr_act;
    region_e          region_e_w;

    always_comb begin
        cfg_in.rs_width = cfg_rs_width;
        cfg_in.rs_pos   = cfg_rs_pos;
        cfg_in.sr_pos   = cfg_sr_pos;
        cfg_in.ss_pos   = cfg_ss_pos;
        cfg_in.tr_width = cfg_tr_width;
        cfg_in.guard    = cfg_guard;
        cfg_in.dummy    = cfg_dummy;
        cfg_in.ob       = cfg_ob;
        cfg_in.en       = cfg_en;
        cfg_in.rs_inv   = cfg_rs_inv;
        cfg_in.tr_inv   = cfg_tr_inv;
        cfg_in.clk_inv  = cfg_clk_inv;
        cfg_in.sig_inv  = cfg_sig_inv;
    end

    ccd_line_seq #(
        .CNT_W(CNT_W), .PIX_W(PIX_W), .ACTIVE_PIX(ACTIVE_PIX),
        .TR_MIN(TR_MIN), .GUARD_MIN(GUARD_MIN)
    ) u_seq (
        .clk(clk), .rst(rst), .cfg_in(cfg_in), .cfg_act(cfg_act),
        .st(st), .phase(phase), .pix(pix), .line_start(line_start)
    );

    ccd_pix_decode #(.PIX_W(PIX_W)) u_dec (
        .clk(clk), .rst(rst), .st(st), .phase(phase), .pix(pix),
        .rs_pos(cfg_act.rs_pos), .rs_width(cfg_act.rs_width),
        .sr_pos(cfg_act.sr_pos), .ss_pos(cfg_act.ss_pos),
        .dummy(cfg_act.dummy), .ob(cfg_act.ob),
        .phi_lvl(phi_lvl), .rs_act(rs_act), .tr_act(tr_act),
        .sr(sr), .ss(ss), .region(region_e_w)
    );

    ccd_out_drive u_drv (
        .phi_lvl(phi_lvl), .rs_act(rs_act), .tr_act(tr_act),
        .en(cfg_act.en), .rs_inv(cfg_act.rs_inv), .tr_inv(cfg_act.tr_inv),
        .clk_inv(cfg_act.clk_inv),
        .phi1(phi1), .phi2(phi2), .rs(rs), .tr(tr)
    );

    assign region  = region_e_w;
    assign sig_pol = cfg_act.sig_inv;

    // R4: shift clocks hold still outside the pixel section
    a_r4_phi_frozen: assert property (@(posedge clk) disable iff (rst)
        (st != ST_PIX && $past(st) != ST_PIX) |-> ($stable(phi1) && $stable(phi2)));

    // R8: region is nonzero exactly while strobes may fire
    a_r8_strobe_region: assert property (@(posedge clk) disable iff (rst)
        (sr || ss) |-> (region != 2'd0));
endmodule

// File: tb/ccd_timing_gen_bench.sv
`timescale 1ns/1ps
module ccd_timing_gen_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] cfg_rs_width = 4'd0, cfg_rs_pos = 4'd10, cfg_sr_pos = 4'd14, cfg_ss_pos = 4'd8;
    logic [3:0] cfg_tr_width = 4'd0, cfg_guard = 4'd0, cfg_dummy = 4'd2, cfg_ob = 4'd5;
    logic [3:0] cfg_en = 4'hF;
    logic cfg_rs_inv = 1'b0, cfg_tr_inv = 1'b0, cfg_clk_inv = 1'b0, cfg_sig_inv = 1'b0;
    logic phi1, phi2, rs, tr, sr, ss, line_start, sig_pol;
    logic [1:0] region;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    ccd_timing_gen u_ccd_timing_gen (
        .clk(clk), .rst(rst),
        .cfg_rs_width(cfg_rs_width), .cfg_rs_pos(cfg_rs_pos),
        .cfg_sr_pos(cfg_sr_pos), .cfg_ss_pos(cfg_ss_pos),
        .cfg_tr_width(cfg_tr_width), .cfg_guard(cfg_guard),
        .cfg_dummy(cfg_dummy), .cfg_ob(cfg_ob), .cfg_en(cfg_en),
        .cfg_rs_inv(cfg_rs_inv), .cfg_tr_inv(cfg_tr_inv),
        .cfg_clk_inv(cfg_clk_inv), .cfg_sig_inv(cfg_sig_inv),
        .phi1(phi1), .phi2(phi2), .rs(rs), .tr(tr), .sr(sr), .ss(ss),
        .region(region), .line_start(line_start), .sig_pol(sig_pol)
    );

    // {cycle, phi1 phi2 rs tr sr ss region}
    localparam int NV = 20;
    localparam logic [23:0] VEC [NV] = '{
        {16'd0,   8'h80}, {16'd19,  8'h80}, {16'd20,  8'h90}, {16'd39,  8'h90},
        {16'd40,  8'h80}, {16'd59,  8'h80}, {16'd60,  8'h81}, {16'd67,  8'h81},
        {16'd68,  8'h45}, {16'd69,  8'h41}, {16'd70,  8'h61}, {16'd71,  8'h41},
        {16'd74,  8'h49}, {16'd75,  8'h41}, {16'd76,  8'h81}, {16'd92,  8'h82},
        {16'd171, 8'h42}, {16'd172, 8'h83}, {16'd299, 8'h43}, {16'd300, 8'h80}
    };

    function automatic logic [7:0] obs();
        return {phi1, phi2, rs, tr, sr, ss, region};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic wait_cyc(input int k);
        while (cyc != k) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state, R10 first line start
        check("R11 reset state", {24'd0, obs()}, 32'h80);
        check("R10 line_start at reset", {31'd0, line_start}, 32'd1);
        check("R10 sig_pol", {31'd0, sig_pol}, 32'd0);

        // line 1: R1 R2 R3 R4 R8 vectors
        for (int i = 0; i < NV; i++) begin
            wait_cyc(int'(VEC[i][23:8]));
            check("R1 R2 R3 R4 R8 vector", {24'd0, obs()}, {24'd0, VEC[i][7:0]});
        end
        check("R10 line_start next line", {31'd0, line_start}, 32'd1);
        wait_cyc(301);
        check("R10 line_start single", {31'd0, line_start}, 32'd0);

        // mid-line change, must wait for line 3
        wait_cyc(310);
        cfg_rs_width = 4'd2; cfg_tr_inv = 1'b1; cfg_guard = 4'd2; cfg_tr_width = 4'd3;
        wait_cyc(320);
        check("R9 tr unchanged mid-line", {31'd0, tr}, 32'd1);
        wait_cyc(370);
        check("R9 rs start line2", {31'd0, rs}, 32'd1);
        wait_cyc(371);
        check("R9 rs width unchanged line2", {31'd0, rs}, 32'd0);

        // line 3 starts at 600 with new settings
        wait_cyc(600);
        check("R10 line_start line3", {31'd0, line_start}, 32'd1);
        check("R6 tr inverted idle", {31'd0, tr}, 32'd1);
        wait_cyc(621);
        check("R4 guard 22 cycles", {31'd0, tr}, 32'd1);
        wait_cyc(622);
        check("R4 R6 tr active low", {31'd0, tr}, 32'd0);
        wait_cyc(644);
        check("R4 tr width 23", {31'd0, tr}, 32'd0);
        wait_cyc(645);
        check("R4 tr ends", {31'd0, tr}, 32'd1);
        wait_cyc(666);
        check("R4 R8 trailing guard", {30'd0, region}, 32'd0);
        wait_cyc(667);
        check("R4 R8 first pixel", {30'd0, region}, 32'd1);
        wait_cyc(677);
        check("R2 rs wide start", {31'd0, rs}, 32'd1);
        wait_cyc(679);
        check("R2 rs wide third cycle", {31'd0, rs}, 32'd1);
        wait_cyc(680);
        check("R2 rs wide end", {31'd0, rs}, 32'd0);

        // line 4 at 907: phi1 and rs disabled, rs inverted
        wait_cyc(700);
        cfg_en = 4'b1010; cfg_rs_inv = 1'b1; cfg_tr_inv = 1'b0;
        wait_cyc(930);
        check("R6 tr active high line4", {31'd0, tr}, 32'd1);
        wait_cyc(974);
        check("R5 phi1 disabled", {30'd0, phi1, phi2}, 32'd0);
        check("R5 R6 rs disabled inverted", {31'd0, rs}, 32'd1);
        wait_cyc(982);
        check("R5 phi2 still runs", {30'd0, phi1, phi2}, 32'd1);
        wait_cyc(984);
        check("R5 rs held inactive", {31'd0, rs}, 32'd1);

        // reset in mid-line with clock inversion settings pending
        cfg_clk_inv = 1'b1; cfg_en = 4'b0101; cfg_rs_inv = 1'b1; cfg_sig_inv = 1'b1;
        cfg_guard = 4'd0; cfg_tr_width = 4'd0; cfg_rs_width = 4'd0;
        do_reset();
        check("R11 reset mid-line region", {30'd0, region}, 32'd0);
        check("R11 R10 line_start after reset", {31'd0, line_start}, 32'd1);
        check("R9 R10 sig_pol captured in reset", {31'd0, sig_pol}, 32'd1);
        wait_cyc(60);
        check("R7 swapped phase0", {30'd0, phi1, phi2}, 32'd2);
        wait_cyc(68);
        check("R7 swapped phase8", {30'd0, phi1, phi2}, 32'd3);
        wait_cyc(70);
        check("R6 rs active low", {31'd0, rs}, 32'd0);
        wait_cyc(71);
        check("R6 rs back high", {31'd0, rs}, 32'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule